// File: doc/BRIEF.md
# CAS-before-RAS Refresh and Initialization Sequencer

This block owns the refresh duty for a multiplexed-address DRAM array built from two banks of parts. After reset it waits out the power-up pause. It then runs a burst of dummy CAS-before-RAS cycles that prime the refresh counters inside the parts. Only after that does it tell the access controller that the array is usable. From then on an interval timer produces refresh demands. Each demand is counted in a small saturating counter of pending refreshes.

The block raises a request while demands are pending and waits for a grant from the access controller. The controller grants only when no row strobe is active, or right after it closes a page. On a grant the block takes over the strobes for one refresh cycle. All column strobes go low first. Both row strobes then fall together with the write enable held high, so both banks refresh at once. A precharge interval follows. The last cycle of that precharge is flagged with a one-cycle done pulse. No row address is needed, because the parts supply it from their own counters.

All timing is given in nanoseconds together with the clock period, and the block derives its cycle counts from them. With the defaults (20 ns clock) this gives a 10000-cycle pause, 1 cycle of CAS setup, 3 cycles of RAS low and 3 cycles of precharge, so a full cycle lasts 7 clocks. The interval timer fires every 780 clocks (15.6 µs), which yields more than 1024 refreshes in any 16 ms.

Top module: `cbr_refresh_seq`

## Requirements
- R1: After reset release, every strobe stays high (ras_n all ones, cas_n all ones), ref_drive stays low, and no done pulse occurs for the first PAUSE_CYC clock edges (10000 at defaults, at least 200 µs). The first CAS low is visible right after edge number PAUSE_CYC.
- R2: Once the pause ends, the block runs INIT_CYCLES (8) refresh cycles back to back without needing a grant. init_done rises right after the last of them and stays high. ref_req is never high while init_done is low.
- R3: Once init_done is high, the interval timer adds one pending refresh every INT_CYC clocks (780 at defaults, 15.6 µs). The first is added INT_CYC clocks after init_done rises.
- R4: In every refresh cycle all CAS lines go low CSR_CYC clocks (at least 5 ns and at least the 10 ns WE setup) before the RAS lines fall. They stay low until the RAS lines rise again.
- R5: RAS stays low for RAS_CYC clocks (at least 60 ns and at least the 15 ns CAS hold). A precharge of RP_CYC clocks follows, long enough for both 40 ns and a 110 ns whole cycle. The defaults are 1, 3 and 3 clocks.
- R6: we_n is high whenever ref_drive is high.
- R7: Both ras_n bits always carry the same value, and all cas_n bits always carry the same value. ref_drive is high for exactly the CAS setup, RAS low and precharge clocks of each cycle.
- R8: While init_done is high, the state is idle and at least one refresh is pending, ref_req is high and the strobes stay high. The refresh starts (CAS low) on the clock after ref_grant is sampled high. ref_done is a one-clock pulse on the last precharge clock.
- R9: The pending count saturates at 2**PEND_W-1 (7 at defaults). After the grant has been withheld for more than that many intervals, a steady grant yields exactly that many refresh cycles, after which ref_req falls.
- R10: ref_grant has no effect while ref_req is low: the strobes stay high and ref_drive stays low. ref_req falls once the pending count reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_grant | input | 1 | Access controller allows a refresh to start |
| ref_req | output | 1 | A refresh is pending and the block is idle |
| ref_drive | output | 1 | The block owns the strobes this clock |
| ref_done | output | 1 | One-clock pulse on the last precharge clock of each cycle |
| init_done | output | 1 | Initialization is complete and host accesses may begin |
| ras_n | output | NUM_RAS | Row strobes, active low, one per bank |
| cas_n | output | NUM_CAS | Column strobes, active low, one per byte lane |
| we_n | output | 1 | Write enable, held high during refresh |

## Verification
Every internal counter in this block shows up on the strobe pins within a single refresh cycle or a single interval. A wrong phase counter stretches or shortens a RAS low or precharge window, which is visible within seven clocks. A wrong init count moves the init_done edge by a multiple of seven clocks. A wrong interval or pause limit moves the first request or the first CAS edge by a fixed number of clocks. The pending counter is less direct: a saturation or wrap fault only appears when a long-withheld grant is released, as a wrong number of back-to-back done pulses. The bench therefore compares exact edge numbers and pulse counts, not just the order of events.

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq #(
  parameter int CLK_NS      = 20,
  parameter int PAUSE_NS    = 200000,
  parameter int INTERVAL_NS = 15600,
  parameter int INIT_CYCLES = 8,
  parameter int T_CSR_NS    = 5,
  parameter int T_WSU_NS    = 10,
  parameter int T_CHR_NS    = 15,
  parameter int T_RAS_NS    = 60,
  parameter int T_RP_NS     = 40,
  parameter int T_RC_NS     = 110,
  parameter int PEND_W      = 3,
  parameter int NUM_RAS     = 2,
  parameter int NUM_CAS     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_grant,
  output logic               ref_req,
  output logic               ref_drive,
  output logic               ref_done,
  output logic               init_done,
  output logic [NUM_RAS-1:0] ras_n,
  output logic [NUM_CAS-1:0] cas_n,
  output logic               we_n
);

  localparam int PAUSE_CYC = (PAUSE_NS + CLK_NS - 1) / CLK_NS;
  localparam int INT_CYC   = (INTERVAL_NS + CLK_NS - 1) / CLK_NS;
  localparam int SU_NS     = (T_CSR_NS > T_WSU_NS) ? T_CSR_NS : T_WSU_NS;
  localparam int CSR_RAW   = (SU_NS + CLK_NS - 1) / CLK_NS;
  localparam int CSR_CYC   = (CSR_RAW < 1) ? 1 : CSR_RAW;
  localparam int RASL_RAW  = (T_RAS_NS + CLK_NS - 1) / CLK_NS;
  localparam int CHR_RAW   = (T_CHR_NS + CLK_NS - 1) / CLK_NS;
  localparam int RAS_CYC   = (RASL_RAW > CHR_RAW) ? RASL_RAW : CHR_RAW;
  localparam int RP_RAW    = (T_RP_NS + CLK_NS - 1) / CLK_NS;
  localparam int RC_CYC    = (T_RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int RP_CYC    = (RP_RAW > RC_CYC - RAS_CYC) ? RP_RAW : RC_CYC - RAS_CYC;
  localparam int TMR_MAX   = (PAUSE_CYC > INT_CYC) ? PAUSE_CYC : INT_CYC;
  localparam int TMR_W     = $clog2(TMR_MAX + 1);
  localparam int INIT_W    = $clog2(INIT_CYCLES + 1);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_CAS, S_RAS, S_PRE} state_t;

  state_t            st;
  logic [7:0]        ph;
  logic [TMR_W-1:0]  tmr;
  logic [TMR_W-1:0]  itmr;
  logic [INIT_W-1:0] init_left;
  logic [PEND_W-1:0] pend;
  logic              tick, start, ph_end;

  assign tick      = init_done && (itmr == TMR_W'(INT_CYC - 1));
  assign ref_req   = init_done && (st == S_IDLE) && (pend != '0);
  assign start     = ref_req && ref_grant;
  assign ref_drive = (st == S_CAS) || (st == S_RAS) || (st == S_PRE);
  assign ras_n     = {NUM_RAS{st != S_RAS}};
  assign cas_n     = {NUM_CAS{!((st == S_CAS) || (st == S_RAS))}};
  assign we_n      = 1'b1;
  assign ph_end    = (st == S_CAS && ph == 8'(CSR_CYC - 1)) ||
                     (st == S_RAS && ph == 8'(RAS_CYC - 1)) ||
                     (st == S_PRE && ph == 8'(RP_CYC - 1));
  assign ref_done  = (st == S_PRE) && ph_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PAUSE;
      ph        <= '0;
      tmr       <= '0;
      init_left <= INIT_W'(INIT_CYCLES);
      init_done <= 1'b0;
    end else begin
      case (st)
        S_PAUSE: begin
          if (tmr == TMR_W'(PAUSE_CYC - 1)) begin
            st <= S_CAS;
            ph <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_IDLE: begin
          if (start) begin
            st <= S_CAS;
            ph <= '0;
          end
        end
        S_CAS: begin
          if (ph_end) begin
            st <= S_RAS;
            ph <= '0;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        S_RAS: begin
          if (ph_end) begin
            st <= S_PRE;
            ph <= '0;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        S_PRE: begin
          if (ph_end) begin
            ph <= '0;
            if (!init_done && init_left > INIT_W'(1)) begin
              init_left <= init_left - 1'b1;
              st        <= S_CAS;
            end else begin
              init_done <= 1'b1;
              st        <= S_IDLE;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: st <= S_PAUSE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      itmr <= '0;
      pend <= '0;
    end else begin
      if (init_done) itmr <= tick ? '0 : itmr + 1'b1;
      if (tick && !start && pend != PEND_MAX) pend <= pend + 1'b1;
      else if (start && !tick)                pend <= pend - 1'b1;
    end
  end

  logic [15:0] lo_len, hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_len <= '0;
      hi_len <= '1;
    end else begin
      lo_len <= ras_n[0] ? '0 : (lo_len == '1 ? lo_len : lo_len + 1'b1);
      hi_len <= !ras_n[0] ? '0 : (hi_len == '1 ? hi_len : hi_len + 1'b1);
    end
  end

  a_r4_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n[0]) |-> (cas_n == '0) && ($past(cas_n) == '0));
  a_r4_cas_held_to_ras_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n[0]) |-> ($past(cas_n) == '0));
  a_r5_ras_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n[0]) |-> (lo_len >= 16'(RAS_CYC)));
  a_r5_precharge_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n[0]) |-> (hi_len >= 16'(RP_CYC + CSR_CYC)));
  a_r2_no_req_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> init_done);
  a_r8_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n[0]) && init_done) |-> ($past(ref_grant) && $past(ref_req)));
  a_r9_pending_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend) == PEND_MAX && !$past(start)) |-> (pend == PEND_MAX));

endmodule

// File: tb/cbr_refresh_seq_tb.sv
module cbr_refresh_seq_tb;

  localparam int PAUSE   = 10000;
  localparam int CLEN    = 7;
  localparam int INITN   = 8;
  localparam int READY   = PAUSE + INITN * CLEN;
  localparam int INTV    = 780;
  localparam int REQ1    = READY + INTV;
  localparam int SATN    = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_grant = 1'b0;
  logic       ref_req, ref_drive, ref_done, init_done, we_n;
  logic [1:0] ras_n;
  logic [3:0] cas_n;
  int         n;
  int         checks = 0;
  int         fails = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) n <= 0; else n <= n + 1;

  cbr_refresh_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .ref_req(ref_req),
    .ref_drive(ref_drive), .ref_done(ref_done), .init_done(init_done),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset_state;
    chk(ras_n == 2'b11 && cas_n == 4'hF, "R7", "strobes idle in reset", {ras_n, cas_n}, 8'h3F);
    chk(!ref_drive && !ref_done, "R1", "no drive in reset", {ref_drive, ref_done}, 0);
    chk(!init_done && !ref_req, "R2", "not ready in reset", {init_done, ref_req}, 0);
  endtask

  task automatic t_power_up;
    int first_cas = -1;
    int e_pause = 0, e_cas = 0, e_ras = 0, e_done = 0, e_drv = 0, e_we = 0, e_req = 0, e_rdy = 0;
    int dones = 0;
    while (n < READY) begin
      @(negedge clk);
      if (cas_n != 4'hF && first_cas < 0) first_cas = n;
      if (n < PAUSE) begin
        if (ras_n != 2'b11 || cas_n != 4'hF || ref_drive || ref_done) e_pause++;
      end else if (n < READY) begin
        int p = (n - PAUSE) % CLEN;
        if (cas_n != ((p <= 3) ? 4'h0 : 4'hF)) e_cas++;
        if (ras_n != ((p >= 1 && p <= 3) ? 2'b00 : 2'b11)) e_ras++;
        if (ref_done != (p == 6)) e_done++;
        if (!ref_drive) e_drv++;
        if (!we_n) e_we++;
      end
      if (ref_done) dones++;
      if (ref_req) e_req++;
      if (init_done != (n >= READY)) e_rdy++;
    end
    chk(e_pause == 0, "R1", "activity during pause", e_pause, 0);
    chk(first_cas == PAUSE, "R1", "first CAS edge", first_cas, PAUSE);
    chk(e_cas == 0, "R4", "CAS pattern errors", e_cas, 0);
    chk(e_ras == 0, "R5", "RAS pattern errors", e_ras, 0);
    chk(e_drv == 0, "R7", "drive gaps during init", e_drv, 0);
    chk(e_we == 0, "R6", "WE low during refresh", e_we, 0);
    chk(dones == INITN && e_done == 0, "R2", "init done pulses", dones, INITN);
    chk(e_req == 0 && e_rdy == 0, "R2", "ready edge and no early req", e_req + e_rdy, 0);
    @(negedge clk);
    chk(!ref_drive && ras_n == 2'b11 && cas_n == 4'hF, "R7", "released after init",
        {ref_drive, ras_n, cas_n}, 8'h3F);
  endtask

  task automatic t_interval_and_grant;
    int e_seq = 0;
    while (!ref_req && n < REQ1 + 100) @(negedge clk);
    chk(n == REQ1, "R3", "first request edge", n, REQ1);
    repeat (3) @(negedge clk);
    chk(ref_req && !ref_drive && cas_n == 4'hF, "R8", "waits for grant",
        {ref_req, ref_drive, cas_n}, 6'h2F);
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    chk(cas_n == 4'h0 && ras_n == 2'b11 && ref_drive, "R8", "CAS low after grant",
        {ras_n, cas_n}, 6'h30);
    for (int k = 1; k < CLEN; k++) begin
      @(negedge clk);
      if (ras_n != ((k <= 3) ? 2'b00 : 2'b11)) e_seq++;
      if (ref_done != (k == CLEN - 1)) e_seq++;
      if (!ref_drive || !we_n) e_seq++;
    end
    chk(e_seq == 0, "R8", "granted cycle shape", e_seq, 0);
    @(negedge clk);
    chk(!ref_req && !ref_drive, "R10", "request cleared", {ref_req, ref_drive}, 0);
  endtask

  task automatic t_grant_ignored;
    int e = 0;
    ref_grant = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (ref_drive || ras_n != 2'b11 || cas_n != 4'hF) e++;
    end
    ref_grant = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (ref_drive || ras_n != 2'b11 || cas_n != 4'hF) e++;
    end
    chk(e == 0, "R10", "grant without request", e, 0);
    while (!ref_req && n < REQ1 + INTV + 100) @(negedge clk);
    chk(n == REQ1 + INTV, "R3", "second request edge", n, REQ1 + INTV);
  endtask

  task automatic t_saturation;
    int dones = 0;
    while (n < REQ1 + 10 * INTV + 50) @(negedge clk);
    chk(ref_req, "R9", "request held while withheld", ref_req, 1);
    ref_grant = 1'b1;
    repeat (150) begin
      @(negedge clk);
      if (ref_done) dones++;
    end
    ref_grant = 1'b0;
    chk(dones == SATN, "R9", "refreshes after saturation", dones, SATN);
    chk(!ref_req, "R9", "request drops after drain", ref_req, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_power_up();
    t_interval_and_grant();
    t_grant_ignored();
    t_saturation();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", n, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule